// File: doc/BRIEF.md
# 10BASE-T Transmit Encoder with Jabber Lockout

This block is the digital transmit path of a 10 Mb/s twisted-pair port. It takes 4-bit NRZ nibbles while a transmit enable is high and shifts each nibble out least significant bit first. It Manchester-encodes every bit onto a pair of complementary line-sense outputs. When no frame is being sent, it emits a short normal link pulse at a fixed interval.

A jabber guard watches the transmit enable. If the enable stays high for too long, the guard locks transmission off and raises a status output. While it is locked, link pulses are also withheld. The lock is released only after the enable has been low without a break for a long quiet interval. Every timer is a parameter given in clock cycles, so a small configuration can be run quickly.

The controller has four named states:
- `ST_IDLE`: line quiet, link timer counting.
- `ST_LINK`: link pulse on the line.
- `ST_DATA`: Manchester data on the line.
- `ST_JAB`: locked out.

The transitions are:
- IDLE→DATA on enable. This has priority over a due link pulse.
- IDLE→LINK when the link gap has elapsed.
- LINK→IDLE when the pulse is done.
- DATA→DATA at a nibble end while the enable is high, which loads the next nibble.
- DATA→IDLE at a nibble end while the enable is low.
- any state→JAB when the jabber lock is set.
- JAB→IDLE when the lock is released.

Top module: `tenbt_tx`

## Requirements
- R1: `nib_take` is high in a cycle where `txd` is captured at the next clock edge. This happens on the first cycle of enable while idle, and on the last cycle of each nibble while the enable is still high. `txd[0]` is transmitted first and `txd[3]` last.
- R2: Each bit lasts 2*HALF_CYC cycles. A 1 is sent as low for HALF_CYC cycles and then high for HALF_CYC cycles. A 0 is sent as high and then low. While data is driven, `line_act` is 1 and `line_n` is the complement of `line_p`.
- R3: Consecutive nibbles follow with no gap. If the enable is low at the last cycle of a nibble, the frame ends. From the next cycle, `line_act`, `line_p` and `line_n` are all 0.
- R4: After NLP_GAP consecutive idle cycles, `line_p` is high for NLP_WIDTH cycles while `line_n` stays 0, and then the gap count restarts. Counting begins afresh after reset and after every frame or lock.
- R5: After reset, `line_p`, `line_n`, `line_act`, `nib_take` and `jabber` are all 0.
- R6: Once the enable has been sampled high on JAB_LIMIT consecutive edges, `jabber` is 1. From the following cycle, `line_act` is 0, and `nib_take` stays 0 while `jabber` is 1.
- R7: `jabber` returns to 0 only after the enable has been sampled low on UNJAB_IDLE consecutive edges. Any high sample restarts this count.
- R8: While `jabber` is 1, no link pulse is sent, even if the lock lasts longer than NLP_GAP.
- R9: After the lock is released, the block is idle again. The next link pulse follows the full gap, and frames are accepted as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| txd | input | NIB_W | Transmit nibble |
| nib_take | output | 1 | `txd` is captured at the next edge |
| line_p | output | 1 | Positive line sense (Manchester level or link pulse) |
| line_n | output | 1 | Negative line sense (complement during data) |
| line_act | output | 1 | Data is being driven |
| jabber | output | 1 | Jabber lock active |

## Verification
A wrong half-bit or bit-index counter shows on `line_p` within one half-bit, as a swapped level or a misplaced transition. A miscounted nibble boundary appears as `nib_take` in the wrong cycle and a shifted stream in the following nibble. Errors in the link timer or the jabber counters are only visible at their boundaries. For that reason, the pulse position, the trip edge and the release edge are each sampled at the exact cycle and at the cycle before it.

// File: rtl/tenbt_pkg.sv
package tenbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINK = 2'd1,
        ST_DATA = 2'd2,
        ST_JAB  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/tenbt_nibble_ser.sv
module tenbt_nibble_ser #(
    parameter int NIB_W    = 4,
    parameter int HALF_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [NIB_W-1:0] nib_in,
    output logic             level,
    output logic             nib_last
);
    localparam int HALVES = 2 * NIB_W;
    localparam int HW     = $clog2(HALVES);
    localparam int CW     = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [NIB_W-1:0] shreg;
    logic [HW-1:0]    hidx;
    logic [CW-1:0]    cyc;
    logic             cur_bit;
    logic             half_end;

    assign half_end = (cyc == CW'(HALF_CYC - 1));
    assign cur_bit  = shreg[hidx[HW-1:1]];
    assign level    = hidx[0] ? cur_bit : ~cur_bit;
    assign nib_last = run && half_end && (hidx == HW'(HALVES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            hidx  <= '0;
            cyc   <= '0;
        end else if (load) begin
            shreg <= nib_in;
            hidx  <= '0;
            cyc   <= '0;
        end else if (run) begin
            if (half_end) begin
                cyc  <= '0;
                hidx <= (hidx == HW'(HALVES - 1)) ? '0 : hidx + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    AST_LEVEL_HOLDS_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !half_end) |=> $stable(level)); // R2
endmodule

// File: rtl/tenbt_link_timer.sv
module tenbt_link_timer #(
    parameter int NLP_GAP   = 319998,
    parameter int NLP_WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_en,
    input  logic pulse_on,
    output logic fire,
    output logic pulse_done
);
    localparam int GW = $clog2(NLP_GAP + 1);
    localparam int WW = $clog2(NLP_WIDTH + 1);

    logic [GW-1:0] gap_cnt;
    logic [WW-1:0] wid_cnt;

    assign fire       = gap_en && (gap_cnt == GW'(NLP_GAP - 1));
    assign pulse_done = pulse_on && (wid_cnt == WW'(NLP_WIDTH - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (!gap_en || fire) begin
            gap_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !pulse_on) begin
            wid_cnt <= '0;
        end else begin
            wid_cnt <= wid_cnt + 1'b1;
        end
    end

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_on |-> (wid_cnt < WW'(NLP_WIDTH))); // R4
endmodule

// File: rtl/tenbt_jabber_guard.sv
module tenbt_jabber_guard #(
    parameter int JAB_LIMIT  = 1000000,
    parameter int UNJAB_IDLE = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic jab
);
    localparam int RW = $clog2(JAB_LIMIT + 1);
    localparam int QW = $clog2(UNJAB_IDLE + 1);

    logic [RW-1:0] run_cnt;
    logic [QW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            run_cnt <= '0;
        end else if (run_cnt != RW'(JAB_LIMIT)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jab       <= 1'b0;
            quiet_cnt <= '0;
        end else if (!jab) begin
            quiet_cnt <= '0;
            if (tx_en && run_cnt == RW'(JAB_LIMIT - 1)) begin
                jab <= 1'b1;
            end
        end else if (tx_en) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt == QW'(UNJAB_IDLE - 1)) begin
            quiet_cnt <= '0;
            jab       <= 1'b0;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    AST_JAB_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab) |-> $past(tx_en)); // R6
    AST_JAB_HELD_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (jab && tx_en) |=> jab); // R7
endmodule

// File: rtl/tenbt_tx.sv
module tenbt_tx
    import tenbt_pkg::*;
#(
    parameter int NIB_W      = 4,
    parameter int HALF_CYC   = 1,
    parameter int NLP_GAP    = 319998,
    parameter int NLP_WIDTH  = 2,
    parameter int JAB_LIMIT  = 1000000,
    parameter int UNJAB_IDLE = 10000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    output logic             nib_take,
    output logic             line_p,
    output logic             line_n,
    output logic             line_act,
    output logic             jabber
);
    tx_state_e state, state_nx;
    logic      level, nib_last, fire, pulse_done, jab, load;

    tenbt_nibble_ser #(.NIB_W(NIB_W), .HALF_CYC(HALF_CYC)) ser_i (
        .clk(clk), .rst_n(rst_n), .load(load), .run(state == ST_DATA),
        .nib_in(txd), .level(level), .nib_last(nib_last)
    );

    tenbt_link_timer #(.NLP_GAP(NLP_GAP), .NLP_WIDTH(NLP_WIDTH)) nlp_i (
        .clk(clk), .rst_n(rst_n), .gap_en(state == ST_IDLE),
        .pulse_on(state == ST_LINK), .fire(fire), .pulse_done(pulse_done)
    );

    tenbt_jabber_guard #(.JAB_LIMIT(JAB_LIMIT), .UNJAB_IDLE(UNJAB_IDLE)) jab_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .jab(jab)
    );

    assign load = tx_en && !jab &&
                  ((state == ST_IDLE) || (state == ST_DATA && nib_last));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (jab)         state_nx = ST_JAB;
                else if (tx_en)  state_nx = ST_DATA;
                else if (fire)   state_nx = ST_LINK;
            end
            ST_LINK: begin
                if (jab)             state_nx = ST_JAB;
                else if (pulse_done) state_nx = ST_IDLE;
            end
            ST_DATA: begin
                if (jab)                     state_nx = ST_JAB;
                else if (nib_last && !tx_en) state_nx = ST_IDLE;
            end
            ST_JAB: begin
                if (!jab) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        nib_take = load;
        jabber   = jab;
        line_act = 1'b0;
        line_p   = 1'b0;
        line_n   = 1'b0;
        unique case (state)
            ST_DATA: begin
                line_act = 1'b1;
                line_p   = level;
                line_n   = ~level;
            end
            ST_LINK: line_p = 1'b1;
            default: ;
        endcase
    end

    AST_JAB_CUTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |=> !line_act); // R6
    AST_JAB_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |=> !line_p); // R8
    AST_TAKE_STARTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |=> line_act); // R1
endmodule

// File: tb/tenbt_tx_tb_top.sv
module tenbt_tx_tb_top;
    localparam int HALF  = 2;
    localparam int GAP   = 40;
    localparam int WID   = 3;
    localparam int JLIM  = 400;
    localparam int UNJ   = 120;
    localparam int NB    = 8 * HALF;
    localparam int P     = GAP + WID;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic [3:0] txd = '0;
    logic nib_take, line_p, line_n, line_act, jabber;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [3:0] nb [16];

    always #2.5 clk = ~clk;

    tenbt_tx #(.NIB_W(4), .HALF_CYC(HALF), .NLP_GAP(GAP), .NLP_WIDTH(WID),
               .JAB_LIMIT(JLIM), .UNJAB_IDLE(UNJ)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .nib_take(nib_take),
        .line_p(line_p), .line_n(line_n), .line_act(line_act), .jabber(jabber)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (line_p || line_act || jabber) step();
    endtask

    task automatic send_frame(input int nn);
        int pos, j, h, e;
        @(negedge clk);
        tx_en = 1'b1;
        txd = nb[0];
        #1;
        chk(nib_take == 1'b1, "R1 first take", nib_take, 1);
        for (int t = 1; t <= nn * NB; t++) begin
            step();
            pos = t - 1;
            j = pos / NB;
            h = (pos % NB) / HALF;
            e = (h % 2 == 1) ? int'(nb[j][h/2]) : int'(!nb[j][h/2]);
            chk(line_act == 1'b1, "R2 act", line_act, 1);
            chk(line_p == e[0], "R1/R2 level", line_p, e);
            chk(line_n == !e[0], "R2 complement", line_n, !e[0]);
            if (t % NB == 0) chk(nib_take == ((t / NB) < nn), "R3 take at nibble end",
                                 nib_take, ((t / NB) < nn));
            if (t % NB == 1) begin
                if (j + 1 < nn) txd = nb[j+1];
                else tx_en = 1'b0;
            end
        end
        step();
        chk(line_act == 1'b0, "R3 end act", line_act, 0);
        chk(line_p == 1'b0 && line_n == 1'b0, "R3 end lines", {line_p, line_n}, 0);
        for (int k = 1; k <= GAP; k++) begin
            step();
            chk(line_p == (k == GAP), "R4 gap after frame", line_p, (k == GAP));
        end
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(line_p == 0 && line_n == 0 && line_act == 0, "R5 lines", {line_p, line_n, line_act}, 0);
        chk(nib_take == 0 && jabber == 0, "R5 status", {nib_take, jabber}, 0);
        rst_n = 1'b1;
        // R4: periodic pulse from reset
        for (int k = 1; k <= 2 * P; k++) begin
            step();
            chk(line_p == ((k % P) >= GAP), "R4 pulse pattern", line_p, ((k % P) >= GAP));
            chk(line_n == 0 && line_act == 0, "R4 n low", {line_n, line_act}, 0);
        end
        wait_idle();
        // R1/R2: all sixteen nibble values in one frame
        for (int i = 0; i < 16; i++) nb[i] = 4'(i);
        send_frame(16);
        wait_idle();
        nb[0] = 4'h9;
        send_frame(1);
        wait_idle();
        nb[0] = 4'h5; nb[1] = 4'hA; nb[2] = 4'h3;
        send_frame(3);
        wait_idle();
        // R6: jabber trip
        @(negedge clk);
        tx_en = 1'b1;
        txd = 4'hC;
        for (int k = 1; k < JLIM; k++) step();
        chk(jabber == 0, "R6 not yet", jabber, 0);
        chk(line_act == 1, "R6 still driving", line_act, 1);
        step();
        chk(jabber == 1, "R6 trip", jabber, 1);
        chk(nib_take == 0, "R6 no take", nib_take, 0);
        step();
        chk(line_act == 0, "R6 drive off", line_act, 0);
        for (int k = 0; k < 50; k++) begin
            step();
            chk(jabber == 1 && nib_take == 0, "R6 locked", {jabber, nib_take}, 2);
            chk(line_p == 0, "R8 no pulse", line_p, 0);
        end
        // R7: low gap interrupted by one high sample
        tx_en = 1'b0;
        for (int k = 0; k < 60; k++) begin
            step();
            chk(line_p == 0, "R8 no pulse", line_p, 0);
        end
        tx_en = 1'b1;
        step();
        tx_en = 1'b0;
        for (int k = 1; k < UNJ; k++) begin
            step();
            chk(line_p == 0 && line_act == 0, "R8 quiet", {line_p, line_act}, 0);
        end
        chk(jabber == 1, "R7 before release", jabber, 1);
        step();
        chk(jabber == 0, "R7 release", jabber, 0);
        // R9: pulse after full gap
        for (int k = 1; k <= GAP + 1; k++) begin
            step();
            chk(line_p == (k == GAP + 1), "R9 first pulse", line_p, (k == GAP + 1));
        end
        wait_idle();
        nb[0] = 4'h6; nb[1] = 4'hF;
        send_frame(2);  // R9 frames accepted again
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule